// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Control

This block steers the front end of a five-stage in-order pipeline. It looks at the instruction in decode and the instruction in execute. When the execute-stage instruction is a load and a source that the decode-stage instruction reads is that load's destination, forwarding cannot supply the value in time. The block then holds the program counter and the fetch/decode register for one cycle and turns the decode-to-execute transfer into a bubble. A bubble is an instruction whose control bits are all cleared, so it writes nothing.

Branches are resolved in decode under a predict-not-taken policy. The two register operands of a decode-stage branch are compared for equality. When they are equal the branch is taken, and the block flushes the one wrongly fetched instruction in the fetch/decode register by turning it into an all-zero no-op.

A stall always wins over a flush. The branch stays in decode and is evaluated again on the next cycle. A one-bit register remembers that a stall has just been issued. This limits every stall to a single cycle, because after one cycle the MEM/WB forwarding path can supply the loaded value.

Top module: `hazard_ctrl`

## Requirements
- R1: A stall is raised when `ex_mem_read` is 1, `ex_dest` is nonzero, and `ex_dest` equals `id_src_a` with `id_use_a` set, or equals `id_src_b` with `id_use_b` set. The previous cycle must not have been a stall.
- R2: While a stall is raised, `pc_we` and `ifid_we` are both 0. Otherwise both are 1.
- R3: `idex_bubble` is 1 exactly in the stall cycles. In those cycles the decode-to-execute control bits are cleared.
- R4: No stall is raised when `ex_mem_read` is 0, when `ex_dest` is 0, or when no used source matches `ex_dest`.
- R5: A stall never lasts two cycles in a row. The cycle after a stall cycle does not stall, even if the inputs still show a load-use match.
- R6: A decode-stage branch (`id_branch` = 1) whose operands `id_opnd_a` and `id_opnd_b` are equal is taken. With no stall it raises `ifid_flush` = 1 and keeps `pc_we` = 1 so the target is fetched.
- R7: `ifid_flush` is 0 when `id_branch` is 0 or when the operands differ.
- R8: If a stall and a taken branch occur in the same cycle, `ifid_flush` is 0 in that cycle. The branch raises the flush in the next cycle if it is still taken.
- R9: After reset the stall history is clear. With idle inputs the outputs are `pc_we` = 1, `ifid_we` = 1, `idex_bubble` = 0 and `ifid_flush` = 0, and a load-use match in the first cycle stalls at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_mem_read | input | 1 | Execute-stage instruction reads memory (a load) |
| ex_dest | input | REG_AW | Destination register of the execute-stage load |
| id_src_a | input | REG_AW | First source register of the decode-stage instruction |
| id_src_b | input | REG_AW | Second source register of the decode-stage instruction |
| id_use_a | input | 1 | Decode-stage instruction reads `id_src_a` |
| id_use_b | input | 1 | Decode-stage instruction reads `id_src_b` |
| id_branch | input | 1 | Decode-stage instruction is a conditional branch |
| id_opnd_a | input | DATA_W | First branch operand value |
| id_opnd_b | input | DATA_W | Second branch operand value |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Clear decode-to-execute control bits |
| ifid_flush | output | 1 | Replace fetch/decode contents with a no-op |

## Verification
Every output is a combinational function of the current inputs and the one stall-history bit. The bench therefore drives inputs on the falling edge and samples the outputs one nanosecond later, in the same cycle. The stall-history bit changes only at a rising edge. The single-cycle stall limit and the deferred flush are checked by holding the inputs across one rising edge and sampling again after the next falling edge. The stall and flush priority is checked in both the cycle of the conflict and the cycle that follows it.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] ex_dest,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_use_a,
  input  logic              id_use_b,
  input  logic              id_branch,
  input  logic [DATA_W-1:0] id_opnd_a,
  input  logic [DATA_W-1:0] id_opnd_b,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble,
  output logic              ifid_flush
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic stalled_q;
  logic hit_a, hit_b, load_use, stall, taken;

  assign hit_a    = id_use_a && (id_src_a == ex_dest);
  assign hit_b    = id_use_b && (id_src_b == ex_dest);
  assign load_use = ex_mem_read && (ex_dest != ZERO_REG) && (hit_a || hit_b);
  assign stall    = load_use && !stalled_q;
  assign taken    = id_branch && (id_opnd_a == id_opnd_b);

  always_ff @(posedge clk) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stall;
  end

  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall;
  assign ifid_flush  = taken && !stall;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ex_mem_read,
  input logic [REG_AW-1:0] ex_dest,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic              id_use_a,
  input logic              id_use_b,
  input logic              id_branch,
  input logic [DATA_W-1:0] id_opnd_a,
  input logic [DATA_W-1:0] id_opnd_b,
  input logic              pc_we,
  input logic              ifid_we,
  input logic              idex_bubble,
  input logic              ifid_flush
);
  p_hold_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we));
  p_move_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_bubble |-> (pc_we && ifid_we));
  p_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_mem_read || ex_dest == '0) |-> !idex_bubble);
  p_single_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> !idex_bubble);
  p_stall_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_read && ex_dest != '0 && id_use_a && id_src_a == ex_dest
     && !$past(idex_bubble)) |-> idex_bubble);
  p_flush_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (id_branch && id_opnd_a == id_opnd_b && pc_we));
  p_flush_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> !idex_bubble);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ex_mem_read = 0, id_use_a = 0, id_use_b = 0, id_branch = 0;
  logic [4:0] ex_dest = 0, id_src_a = 0, id_src_b = 0;
  logic [31:0] id_opnd_a = 0, id_opnd_b = 0;
  logic pc_we, ifid_we, idex_bubble, ifid_flush;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  hazard_ctrl u0 (.*);

  task automatic expect4(string req, logic pw, logic fw, logic bb, logic fl);
    n_chk++;
    if ({pc_we, ifid_we, idex_bubble, ifid_flush} !== {pw, fw, bb, fl}) begin
      n_bad++;
      $display("FAIL %s: pc_we/ifid_we/bubble/flush = %b%b%b%b, expected %b%b%b%b",
               req, pc_we, ifid_we, idex_bubble, ifid_flush, pw, fw, bb, fl);
    end
  endtask

  task automatic idle();
    ex_mem_read = 0; ex_dest = 0; id_src_a = 0; id_src_b = 0;
    id_use_a = 0; id_use_b = 0; id_branch = 0; id_opnd_a = 0; id_opnd_b = 0;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic load(logic [4:0] d, logic [4:0] a, logic ua, logic [4:0] b, logic ub);
    ex_mem_read = 1; ex_dest = d; id_src_a = a; id_use_a = ua; id_src_b = b; id_use_b = ub;
  endtask

  task automatic t_reset();
    step(); expect4("R9 idle", 1, 1, 0, 0);
  endtask

  task automatic t_load_use();
    load(5'd7, 5'd7, 1, 5'd3, 1); #1; expect4("R1 match a", 0, 0, 1, 0);
    step(); expect4("R5 second cycle", 1, 1, 0, 0);
    idle(); step();
    load(5'd9, 5'd2, 1, 5'd9, 1); #1; expect4("R1 R2 R3 match b", 0, 0, 1, 0);
    idle(); step(); expect4("R3 no bubble idle", 1, 1, 0, 0);
  endtask

  task automatic t_no_stall();
    load(5'd4, 5'd4, 0, 5'd4, 0); #1; expect4("R4 sources unused", 1, 1, 0, 0);
    load(5'd0, 5'd0, 1, 5'd0, 1); #1; expect4("R4 dest zero", 1, 1, 0, 0);
    load(5'd6, 5'd1, 1, 5'd2, 1); #1; expect4("R4 mismatch", 1, 1, 0, 0);
    load(5'd6, 5'd6, 1, 5'd6, 1); ex_mem_read = 0; #1; expect4("R4 not a load", 1, 1, 0, 0);
    idle(); step();
  endtask

  task automatic t_held_hazard();
    load(5'd12, 5'd12, 1, 5'd0, 0);
    #1; expect4("R5 stall c0", 0, 0, 1, 0);
    step(); expect4("R5 free c1", 1, 1, 0, 0);
    step(); expect4("R5 stall c2", 0, 0, 1, 0);
    idle(); step();
  endtask

  task automatic t_branch();
    id_branch = 1; id_opnd_a = 32'hDEAD_0001; id_opnd_b = 32'hDEAD_0001;
    #1; expect4("R6 taken", 1, 1, 0, 1);
    id_opnd_b = 32'hDEAD_0002; #1; expect4("R7 unequal", 1, 1, 0, 0);
    id_branch = 0; id_opnd_b = 32'hDEAD_0001; #1; expect4("R7 no branch", 1, 1, 0, 0);
    idle(); step();
  endtask

  task automatic t_priority();
    load(5'd3, 5'd3, 1, 5'd5, 1);
    id_branch = 1; id_opnd_a = 32'h55; id_opnd_b = 32'h55;
    #1; expect4("R8 stall wins", 0, 0, 1, 0);
    step(); expect4("R8 flush next", 1, 1, 0, 1);
    idle(); step();
  endtask

  task automatic t_reset_first();
    rst_n = 0; load(5'd8, 5'd8, 1, 5'd0, 0);
    @(posedge clk); @(posedge clk); #1; rst_n = 1;
    step(); expect4("R9 stall after reset", 0, 0, 1, 0);
    idle(); step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    t_reset();
    t_load_use();
    t_no_stall();
    t_held_hazard();
    t_branch();
    t_priority();
    t_reset_first();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule